// File: doc/BRIEF.md
# ADC Conversion Sequencer

This block is the host-side controller for the conversion pins of an eight-channel ADC that samples all its channels at once. It drives two active-high start strobes. Strobe A starts channels 1 to 4 and strobe B starts channels 5 to 8. The strobes can be raised one group at a time or both together. In oversampling mode both strobes are always driven as one start. After a strobe rises, the sequencer waits for the converter's busy line to go high and then fall. It then drops the strobes and gives a readout engine a one-cycle done pulse.

The sequencer also owns the converter's active-high reset. It asserts that reset while the system reset is held and keeps it high for a set pulse width after release. A re-initialisation request, used after leaving shutdown, reissues the same pulse. After the converter reset falls, a guard time must pass before any strobe may rise. A start request that arrives during the reset pulse or the guard time is held and launched when the guard time ends. Re-initialising during a conversion aborts it: the strobes drop and an abort pulse marks the result invalid.

Top module: `adc_conv_seq`

## Requirements
- R1: While `rst_n` is low, `adc_reset` is 1, both strobes are 0, and `conv_done` and `conv_abort` are 0.
- R2: `adc_reset` stays high for exactly RST_CYCLES clocks after `rst_n` is released. It also stays high for exactly RST_CYCLES clocks after the clock edge that samples `reinit_req`.
- R3: No strobe is high while `adc_reset` is high or during the GUARD_CYCLES clocks after it falls. A start request made in that window is held. It raises the strobes exactly GUARD_CYCLES+1 clocks after `adc_reset` falls.
- R4: Outside oversampling, `grp_sel` bit 0 selects strobe A (channels 1-4) and bit 1 selects strobe B (channels 5-8). Value 2'b11 raises both. A request with 2'b00 starts nothing.
- R5: When `ovs_mode` is 1, a request raises both strobes together, whatever the value of `grp_sel`.
- R6: When the sequencer is idle and ready, and `busy` is low, a start request raises the selected strobes on the next clock edge.
- R7: Strobes stay high until `busy` falls. They drop on the third clock edge after `busy` goes low. `conv_done` is high for exactly that one cycle.
- R8: A start request is ignored while the synchronised busy is high or while any strobe is high. It starts nothing, either then or later.
- R9: A `reinit_req` during a conversion drops both strobes on the sampling edge. It pulses `conv_abort` for one cycle, and no `conv_done` follows for that conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low system reset |
| start_req | input | 1 | Request to start a conversion |
| grp_sel | input | 2 | Group select: bit 0 = channels 1-4, bit 1 = channels 5-8 |
| ovs_mode | input | 1 | Oversampling mode: both strobes always together |
| reinit_req | input | 1 | Reissue the converter reset (after shutdown) |
| busy | input | 1 | Converter busy, asynchronous |
| strobe_a | output | 1 | Start strobe for channels 1-4 |
| strobe_b | output | 1 | Start strobe for channels 5-8 |
| adc_reset | output | 1 | Converter reset, active high |
| conv_done | output | 1 | One-cycle pulse when a conversion ends |
| conv_abort | output | 1 | One-cycle pulse when a conversion is aborted |

## Verification
Conversions are launched with each group select value and with oversampling on while the select is 2'b00. This tells correct per-group steering apart from a mode override that does not work. Requests are made in four places: during the guard time, while busy is high in idle, while the strobes are high, and with an empty select. These separate a request that is held from one that is dropped. The release of busy is timed clock by clock, which catches a strobe released early or late. A mid-conversion re-initialisation checks the abort path and that the reset pulse width is counted again.

// File: rtl/adc_seq_pkg.sv
// Package: shared types for the ADC conversion sequencer.
// Assumes: two channel groups, bit 0 = lower group, bit 1 = upper group.
package adc_seq_pkg;

    localparam int GROUPS = 2;

    typedef logic [GROUPS-1:0] grp_mask_t;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_ARM  = 2'd1,
        SEQ_CONV = 2'd2
    } seq_state_t;

    typedef enum logic [1:0] {
        PH_RESET = 2'd0,
        PH_GUARD = 2'd1,
        PH_READY = 2'd2
    } rst_phase_t;

    // Effective strobe mask: oversampling forces every group on.
    function automatic grp_mask_t eff_mask(input grp_mask_t sel, input logic ovs);
        return ovs ? {GROUPS{1'b1}} : sel;
    endfunction

endpackage

// File: rtl/adc_busy_sync.sv
// Module: adc_busy_sync
// Brings the asynchronous converter busy line into the clock domain with a
// two-flop synchroniser and flags its falling edge for one cycle.
// Assumes: busy pulses are longer than two clock periods.
module adc_busy_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic busy_async,
    output logic busy_s,
    output logic busy_fall
);

    logic meta_q;
    logic sync_q;
    logic prev_q;

    // Two-stage synchroniser plus a delayed copy for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            meta_q <= busy_async;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign busy_s    = sync_q;
    assign busy_fall = prev_q & ~sync_q;

endmodule

// File: rtl/adc_rst_timer.sv
// Module: adc_rst_timer
// Produces the converter reset pulse after system reset or on request, then
// times the guard interval before starts are allowed, and raises ready.
// Assumes: RST_CYCLES >= 1 and GUARD_CYCLES >= 1.
module adc_rst_timer #(
    parameter int RST_CYCLES   = 8,
    parameter int GUARD_CYCLES = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic reinit_req,
    output logic adc_reset,
    output logic ready
);
    import adc_seq_pkg::*;

    localparam int CNT_MAX = (RST_CYCLES > GUARD_CYCLES) ? RST_CYCLES : GUARD_CYCLES;
    localparam int CW      = $clog2(CNT_MAX + 1);
    localparam logic [CW-1:0] RST_LAST   = CW'(RST_CYCLES - 1);
    localparam logic [CW-1:0] GUARD_LAST = CW'(GUARD_CYCLES - 1);

    rst_phase_t    phase_q;
    logic [CW-1:0] cnt_q;

    // Phase sequencer: reset pulse, then guard time, then ready.
    always_ff @(posedge clk) begin
        if (!rst_n || reinit_req) begin
            phase_q   <= PH_RESET;
            cnt_q     <= '0;
            adc_reset <= 1'b1;
            ready     <= 1'b0;
        end else begin
            case (phase_q)
                PH_RESET: begin
                    if (cnt_q == RST_LAST) begin
                        phase_q   <= PH_GUARD;
                        cnt_q     <= '0;
                        adc_reset <= 1'b0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                PH_GUARD: begin
                    if (cnt_q == GUARD_LAST) begin
                        phase_q <= PH_READY;
                        cnt_q   <= '0;
                        ready   <= 1'b1;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: begin
                    phase_q <= PH_READY;
                end
            endcase
        end
    end

    // Checker-side counter: clocks elapsed with adc_reset low, saturating.
    logic [CW-1:0] low_cnt_q;
    always_ff @(posedge clk) begin
        if (!rst_n || adc_reset) begin
            low_cnt_q <= '0;
        end else if (low_cnt_q != CW'(GUARD_CYCLES)) begin
            low_cnt_q <= low_cnt_q + 1'b1;
        end
    end

    assert_reset_blocks_ready_R3: assert property (@(posedge clk) disable iff (!rst_n)
        adc_reset |-> !ready);

    assert_guard_elapsed_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> (low_cnt_q == CW'(GUARD_CYCLES)));

endmodule

// File: rtl/adc_strobe_fsm.sv
// Module: adc_strobe_fsm
// Launches the group strobes on a start request, holds them through the
// conversion, and releases them on busy falling with a done pulse.
// Assumes: busy_s / busy_fall come from a synchroniser; ready from the timer.
module adc_strobe_fsm (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   ready,
    input  logic                   reinit_req,
    input  logic                   start_req,
    input  adc_seq_pkg::grp_mask_t grp_sel,
    input  logic                   ovs_mode,
    input  logic                   busy_s,
    input  logic                   busy_fall,
    output adc_seq_pkg::grp_mask_t strobe,
    output logic                   conv_done,
    output logic                   conv_abort
);
    import adc_seq_pkg::*;

    seq_state_t state_q;
    logic       pend_q;
    grp_mask_t  mask;
    logic       want;
    logic       launch;

    // Launch decision: idle, timer ready, converter quiet, non-empty mask.
    always_comb begin
        mask   = eff_mask(grp_sel, ovs_mode);
        want   = start_req | pend_q;
        launch = (state_q == SEQ_IDLE) && ready && !reinit_req && !busy_s
                 && want && (mask != '0);
    end

    // Main sequencer: idle -> armed (wait busy high) -> converting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= SEQ_IDLE;
            strobe     <= '0;
            conv_done  <= 1'b0;
            conv_abort <= 1'b0;
        end else begin
            conv_done  <= 1'b0;
            conv_abort <= 1'b0;
            if (reinit_req) begin
                if (state_q != SEQ_IDLE) begin
                    conv_abort <= 1'b1;
                end
                state_q <= SEQ_IDLE;
                strobe  <= '0;
            end else begin
                case (state_q)
                    SEQ_IDLE: begin
                        if (launch) begin
                            strobe  <= mask;
                            state_q <= SEQ_ARM;
                        end
                    end
                    SEQ_ARM: begin
                        if (busy_s) begin
                            state_q <= SEQ_CONV;
                        end
                    end
                    SEQ_CONV: begin
                        if (busy_fall) begin
                            strobe    <= '0;
                            conv_done <= 1'b1;
                            state_q   <= SEQ_IDLE;
                        end
                    end
                    default: begin
                        state_q <= SEQ_IDLE;
                        strobe  <= '0;
                    end
                endcase
            end
        end
    end

    // Pending request: held only while the reset/guard window blocks starts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
        end else if (state_q != SEQ_IDLE) begin
            pend_q <= 1'b0;
        end else if (start_req && (!ready || reinit_req)) begin
            pend_q <= 1'b1;
        end else if (launch) begin
            pend_q <= 1'b0;
        end else if (ready && !busy_s && pend_q && (mask == '0)) begin
            pend_q <= 1'b0;
        end
    end

    assert_strobe_needs_ready_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe != '0) |-> ready);

    assert_ovs_pair_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(strobe) == '0 && strobe != '0 && $past(ovs_mode)) |-> (strobe == '1));

    assert_launch_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(strobe) == '0 && strobe != '0) |-> !$past(busy_s));

    assert_hold_until_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(strobe) != '0 && strobe == '0) |-> ($past(busy_fall) || $past(reinit_req)));

    assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        conv_done |=> !conv_done);

    assert_abort_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        conv_abort |-> (strobe == '0 && !conv_done && $past(reinit_req)));

endmodule

// File: rtl/adc_conv_seq.sv
// Module: adc_conv_seq (top)
// Conversion sequencer for a two-group simultaneous-sampling ADC: converter
// reset and guard timing, group/oversampling strobes, busy-based completion.
// Assumes: busy is asynchronous to clk; rst_n is synchronous active-low.
module adc_conv_seq #(
    parameter int RST_CYCLES   = 8,
    parameter int GUARD_CYCLES = 12
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_req,
    input  logic [1:0] grp_sel,
    input  logic       ovs_mode,
    input  logic       reinit_req,
    input  logic       busy,
    output logic       strobe_a,
    output logic       strobe_b,
    output logic       adc_reset,
    output logic       conv_done,
    output logic       conv_abort
);
    import adc_seq_pkg::*;

    logic      ready;
    logic      busy_s;
    logic      busy_fall;
    grp_mask_t strobe;

    adc_busy_sync u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .busy_async (busy),
        .busy_s     (busy_s),
        .busy_fall  (busy_fall)
    );

    adc_rst_timer #(
        .RST_CYCLES   (RST_CYCLES),
        .GUARD_CYCLES (GUARD_CYCLES)
    ) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .reinit_req (reinit_req),
        .adc_reset  (adc_reset),
        .ready      (ready)
    );

    adc_strobe_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .ready      (ready),
        .reinit_req (reinit_req),
        .start_req  (start_req),
        .grp_sel    (grp_sel),
        .ovs_mode   (ovs_mode),
        .busy_s     (busy_s),
        .busy_fall  (busy_fall),
        .strobe     (strobe),
        .conv_done  (conv_done),
        .conv_abort (conv_abort)
    );

    assign strobe_a = strobe[0];
    assign strobe_b = strobe[1];

    assert_reset_excludes_strobes_R1: assert property (@(posedge clk) disable iff (!rst_n)
        adc_reset |-> (!strobe_a && !strobe_b));

    assert_done_abort_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(conv_done && conv_abort));

endmodule

// File: tb/adc_conv_seq_tb_top.sv
// Directed bench for adc_conv_seq: one task per scenario, each self-checking.
module adc_conv_seq_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int RST_C      = 8;
    localparam int GUARD_C    = 12;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       start_req;
    logic [1:0] grp_sel;
    logic       ovs_mode;
    logic       reinit_req;
    logic       busy;
    logic       strobe_a;
    logic       strobe_b;
    logic       adc_reset;
    logic       conv_done;
    logic       conv_abort;

    int n_checks = 0;
    int n_fails  = 0;
    bit done_flag = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    adc_conv_seq #(.RST_CYCLES(RST_C), .GUARD_CYCLES(GUARD_C)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_req  (start_req),
        .grp_sel    (grp_sel),
        .ovs_mode   (ovs_mode),
        .reinit_req (reinit_req),
        .busy       (busy),
        .strobe_a   (strobe_a),
        .strobe_b   (strobe_b),
        .adc_reset  (adc_reset),
        .conv_done  (conv_done),
        .conv_abort (conv_abort)
    );

    // Advance one edge, then sample and drive 1 time unit later.
    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int strobes();
        return {30'd0, strobe_b, strobe_a};
    endfunction

    task automatic pulse_start();
        start_req = 1'b1;
        tick();
        start_req = 1'b0;
    endtask

    // Converter model: busy high, then low; checks release timing (R7).
    task automatic finish_conv(input int exp_mask, input bit poke);
        ticks(2);
        busy = 1'b1;
        ticks(4);
        if (poke) begin
            pulse_start();
            ticks(2);
            check("R8 request during conversion ignored", strobes(), exp_mask);
        end
        busy = 1'b0;
        ticks(2);
        check("R7 strobes held until busy fall seen", strobes(), exp_mask);
        check("R7 no early done", conv_done, 0);
        tick();
        check("R7 strobes drop on third edge", strobes(), 0);
        check("R7 done pulse", conv_done, 1);
        tick();
        check("R7 done lasts one cycle", conv_done, 0);
        ticks(3);
        check("R8 ignored request never launches", strobes(), 0);
    endtask

    task automatic t_powerup();
        int n;
        rst_n = 1'b0; start_req = 1'b0; grp_sel = 2'b01; ovs_mode = 1'b0;
        reinit_req = 1'b0; busy = 1'b0;
        ticks(3);
        check("R1 adc_reset in reset", adc_reset, 1);
        check("R1 strobes in reset", strobes(), 0);
        check("R1 done in reset", conv_done, 0);
        check("R1 abort in reset", conv_abort, 0);
        rst_n = 1'b1;
        n = 0;
        do begin tick(); n++; end while (adc_reset && n < 1000);
        check("R2 power-up pulse width", n, RST_C);
        start_req = 1'b1;
        tick();
        start_req = 1'b0;
        n = 1;
        while (strobes() == 0 && n < 1000) begin tick(); n++; end
        check("R3 held request launches after guard", n, GUARD_C + 1);
        check("R4 group A only", strobes(), 1);
        finish_conv(1, 1'b0);
    endtask

    task automatic t_group(input logic [1:0] sel, input logic ovs, input int exp_mask,
                           input string req);
        grp_sel = sel; ovs_mode = ovs;
        pulse_start();
        check({req, " strobe mask one edge after request (R6)"}, strobes(), exp_mask);
        finish_conv(exp_mask, 1'b1);
        ovs_mode = 1'b0;
    endtask

    task automatic t_empty_sel();
        grp_sel = 2'b00; ovs_mode = 1'b0;
        pulse_start();
        ticks(3);
        check("R4 empty select starts nothing", strobes(), 0);
        grp_sel = 2'b01;
        ticks(2);
        check("R4 empty request not kept", strobes(), 0);
    endtask

    task automatic t_busy_idle();
        grp_sel = 2'b11;
        busy = 1'b1;
        ticks(3);
        pulse_start();
        ticks(2);
        check("R8 request while busy ignored", strobes(), 0);
        busy = 1'b0;
        for (int i = 0; i < 5; i++) begin
            tick();
            check("R8 no done without conversion", conv_done, 0);
        end
        check("R8 no late launch", strobes(), 0);
    endtask

    task automatic t_abort();
        int n;
        grp_sel = 2'b11;
        pulse_start();
        check("R4 both groups", strobes(), 3);
        ticks(2);
        busy = 1'b1;
        ticks(3);
        reinit_req = 1'b1;
        tick();
        reinit_req = 1'b0;
        check("R9 strobes dropped on abort", strobes(), 0);
        check("R9 abort pulse", conv_abort, 1);
        check("R2 reset reissued", adc_reset, 1);
        tick();
        check("R9 abort single cycle", conv_abort, 0);
        busy = 1'b0;
        n = 1;
        while (adc_reset && n < 1000) begin
            tick(); n++;
            check("R9 no done after abort", conv_done, 0);
        end
        check("R2 reinit pulse width", n, RST_C);
        ticks(GUARD_C + 1);
        t_group(2'b10, 1'b0, 2, "R9 recovery");
    endtask

    initial begin
        t_powerup();
        t_group(2'b01, 1'b0, 1, "R4 group A");
        t_group(2'b10, 1'b0, 2, "R4 group B");
        t_group(2'b11, 1'b0, 3, "R4 both groups");
        t_group(2'b00, 1'b1, 3, "R5 oversampling empty select");
        t_group(2'b01, 1'b1, 3, "R5 oversampling overrides select");
        t_empty_sel();
        t_busy_idle();
        t_abort();
        done_flag = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done_flag) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

endmodule